// File: doc/BRIEF.md
# Word-to-Byte Parallel Port Bridge

The bridge connects a 32-bit host register interface to an 8-bit parallel slave port whose device holds a four-byte read buffer and a four-byte write buffer. One host write of a data word becomes four addressed byte write cycles on the port. One host read becomes four addressed byte read cycles, and the four bytes are packed back into one word. The byte placement is fixed little-endian, so the host always sees the same word whatever its own byte order.

Alongside the data path the bridge offers a read-only status word. It merges a sideband ready pin and a three-bit interrupt-ID bus from the slave. Both pass through two-flop synchronizers before they are used. The host selects the data word or the status word with one select input. It starts an operation with a one-cycle request and waits for a one-cycle done pulse. The bridge is busy from the request to the done pulse.

Top module: `word_byte_bridge`

## Requirements
- R1: A host write with `host_sel`=0 produces four byte write cycles. The byte written at port address a (a = 0..3, binary 00..11 on `port_addr`) is word bits [8a+7:8a].
- R2: A host read with `host_sel`=0 produces four byte read cycles. The byte read at port address a lands in `host_rdata` bits [8a+7:8a], and `host_rdata` is valid while `host_done` is high.
- R3: Within one transfer the byte cycles use port addresses 0, 1, 2, 3 in that order.
- R4: `port_cs_n`, `port_wr_n` and `port_rd_n` are active low. A strobe is low only while chip select is low. The two strobes are never low together. The bridge drives `port_data` only during write cycles.
- R5: Each byte cycle has one clock of setup with chip select low, then its strobe low for exactly `STROBE_CYC` clocks (default 2), then one hold clock. Chip select is high for at least one clock between byte cycles.
- R6: `host_busy` stays high from the clock after an accepted request until `host_done`. For a data transfer, `host_done` rises `4*(STROBE_CYC+3)` clock edges after the request edge.
- R7: A status read (`host_sel`=1, `host_we`=0) returns the synchronized ready pin in bit 0, the synchronized interrupt ID in bits 3:1, and zeros in bits 31:4. `host_done` rises on the first edge after the request.
- R8: A status write (`host_sel`=1, `host_we`=1) is ignored. It completes on the first edge, runs no port cycle, leaves `host_rdata` and the slave buffers unchanged, and a later status read returns the same value.
- R9: A change on the ready or interrupt-ID pins reaches the status word only after two clock edges. A status read requested on the edge right after the change still returns the old value.
- R10: After reset, chip select and both strobes are high, `host_busy` and `host_done` are low, and `host_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | One-cycle request, taken only when idle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_sel | input | 1 | 0 = data word, 1 = status word |
| host_wdata | input | 32 | Word to write |
| host_busy | output | 1 | Operation in progress |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read result |
| port_cs_n | output | 1 | Chip select, active low |
| port_wr_n | output | 1 | Write strobe, active low |
| port_rd_n | output | 1 | Read strobe, active low |
| port_addr | output | 2 | Byte address within the slave buffer |
| port_data | inout | 8 | Bidirectional byte bus |
| slv_ready | input | 1 | Asynchronous ready pin from slave |
| slv_irq_id | input | 3 | Asynchronous interrupt ID from slave |

## Verification
A data transfer finishes `4*(STROBE_CYC+3)` edges after its request edge: 20 edges with the default setting. A status access finishes on the first edge. The bench counts edges from each request and checks the latency against these numbers. It checks `host_busy` on every cycle in between. A scoreboard queues the expected word when a read is issued and compares it in the cycle where `host_done` is high. Pin changes for the synchronizer check are made half a clock before the request, so the old value is due on that read and the new value on a read two edges later.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
    localparam int BYTE_W  = 8;
    localparam int N_BYTES = 4;
    localparam int WORD_W  = BYTE_W * N_BYTES;
    localparam int ADDR_W  = $clog2(N_BYTES);
    localparam int IRQ_W   = 3;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_SETUP,
        SQ_STROBE,
        SQ_HOLD,
        SQ_GAP,
        SQ_FIN,
        SQ_STAT
    } seq_state_e;
endpackage

// File: rtl/bit_sync2.sv
module bit_sync2 #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic meta_q;
        logic stab_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= async_in[i];
                stab_q <= meta_q;
            end
        end
        assign sync_out[i] = stab_q;
    end
endmodule

// File: rtl/byte_sequencer.sv
module byte_sequencer
    import bridge_pkg::*;
#(
    parameter int STROBE_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic              sel,
    input  logic [WORD_W-1:0] wdata,
    input  logic [WORD_W-1:0] stat_word,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rdata,
    output logic              cs_n,
    output logic              wr_n,
    output logic              rd_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BYTE_W-1:0] dout,
    output logic              oe,
    input  logic [BYTE_W-1:0] din
);
    localparam int CNT_W = $clog2(STROBE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STROBE_CYC - 1);
    localparam logic [ADDR_W-1:0] IDX_LAST = ADDR_W'(N_BYTES - 1);

    typedef struct packed {
        seq_state_e        state;
        logic [ADDR_W-1:0] idx;
        logic [CNT_W-1:0]  cnt;
        logic              wr;
        logic [WORD_W-1:0] word;
        logic [WORD_W-1:0] rdata;
    } seq_regs_t;

    seq_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            SQ_IDLE: begin
                if (req) begin
                    r_d.wr = we;
                    if (sel) begin
                        if (!we) r_d.rdata = stat_word;
                        r_d.state = SQ_STAT;
                    end else begin
                        r_d.word  = wdata;
                        r_d.idx   = '0;
                        r_d.state = SQ_SETUP;
                    end
                end
            end
            SQ_SETUP: begin
                r_d.cnt   = '0;
                r_d.state = SQ_STROBE;
            end
            SQ_STROBE: begin
                if (r_q.cnt == CNT_LAST) begin
                    if (!r_q.wr) r_d.word[{r_q.idx, 3'b000} +: BYTE_W] = din;
                    r_d.state = SQ_HOLD;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            SQ_HOLD: begin
                if (r_q.idx == IDX_LAST) begin
                    if (!r_q.wr) r_d.rdata = r_q.word;
                    r_d.state = SQ_FIN;
                end else begin
                    r_d.state = SQ_GAP;
                end
            end
            SQ_GAP: begin
                r_d.idx   = r_q.idx + 1'b1;
                r_d.state = SQ_SETUP;
            end
            SQ_FIN:  r_d.state = SQ_IDLE;
            SQ_STAT: r_d.state = SQ_IDLE;
            default: r_d.state = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: SQ_IDLE, idx: '0, cnt: '0, wr: 1'b0,
                     word: '0, rdata: '0};
        end else begin
            r_q <= r_d;
        end
    end

    logic in_cycle;
    assign in_cycle = (r_q.state == SQ_SETUP) || (r_q.state == SQ_STROBE) ||
                      (r_q.state == SQ_HOLD);
    assign busy  = (r_q.state != SQ_IDLE);
    assign done  = (r_q.state == SQ_FIN) || (r_q.state == SQ_STAT);
    assign rdata = r_q.rdata;
    assign cs_n  = !in_cycle;
    assign wr_n  = !((r_q.state == SQ_STROBE) && r_q.wr);
    assign rd_n  = !((r_q.state == SQ_STROBE) && !r_q.wr);
    assign addr  = r_q.idx;
    assign oe    = in_cycle && r_q.wr;
    assign dout  = r_q.word[{r_q.idx, 3'b000} +: BYTE_W];

    // Strobe width counter used only by the checks below
    logic [CNT_W:0] low_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     low_cnt_q <= '0;
        else if (!wr_n || !rd_n)        low_cnt_q <= low_cnt_q + 1'b1;
        else                            low_cnt_q <= '0;
    end

    // R4
    strobe_under_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n || !rd_n) |-> !cs_n);
    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!wr_n && !rd_n));
    // R4
    drive_only_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> (!cs_n && rd_n));
    // R5
    strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == SQ_HOLD) |-> (low_cnt_q == (CNT_W+1)'(STROBE_CYC)));
    // R5
    cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == SQ_SETUP && r_q.idx != '0) |-> $past(cs_n));
    // R3
    byte_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cs_n) && addr != '0) |-> (addr == $past(addr) + 1'b1));
    // R6
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    // R8
    stat_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == SQ_STAT) |-> (cs_n && $stable(addr)));
    // R7
    stat_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == SQ_STAT && !r_q.wr) |-> (rdata[WORD_W-1:IRQ_W+1] == '0));
endmodule

// File: rtl/word_byte_bridge.sv
module word_byte_bridge
    import bridge_pkg::*;
#(
    parameter int STROBE_CYC = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_req,
    input  logic        host_we,
    input  logic        host_sel,
    input  logic [31:0] host_wdata,
    output logic        host_busy,
    output logic        host_done,
    output logic [31:0] host_rdata,
    output logic        port_cs_n,
    output logic        port_wr_n,
    output logic        port_rd_n,
    output logic [1:0]  port_addr,
    inout  wire  [7:0]  port_data,
    input  logic        slv_ready,
    input  logic [2:0]  slv_irq_id
);
    logic [IRQ_W:0]     side_sync;
    logic [WORD_W-1:0]  stat_word;
    logic [BYTE_W-1:0]  dout;
    logic               oe;

    bit_sync2 #(.WIDTH(IRQ_W + 1)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({slv_irq_id, slv_ready}),
        .sync_out (side_sync)
    );

    assign stat_word = {{(WORD_W - IRQ_W - 1){1'b0}}, side_sync};

    byte_sequencer #(.STROBE_CYC(STROBE_CYC)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (host_req),
        .we        (host_we),
        .sel       (host_sel),
        .wdata     (host_wdata),
        .stat_word (stat_word),
        .busy      (host_busy),
        .done      (host_done),
        .rdata     (host_rdata),
        .cs_n      (port_cs_n),
        .wr_n      (port_wr_n),
        .rd_n      (port_rd_n),
        .addr      (port_addr),
        .dout      (dout),
        .oe        (oe),
        .din       (port_data)
    );

    assign port_data = oe ? dout : 'z;
endmodule

// File: tb/tb_word_byte_bridge.sv
`timescale 1ns/1ps
module tb_word_byte_bridge;
    localparam int STRB = 2;
    localparam int DATA_LAT = 4 * (STRB + 3);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_we = 1'b0, host_sel = 1'b0;
    logic [31:0] host_wdata = '0;
    logic        host_busy, host_done;
    logic [31:0] host_rdata;
    logic        port_cs_n, port_wr_n, port_rd_n;
    logic [1:0]  port_addr;
    wire  [7:0]  port_data;
    logic        slv_ready = 1'b0;
    logic [2:0]  slv_irq_id = '0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    word_byte_bridge #(.STROBE_CYC(STRB)) dut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_sel(host_sel), .host_wdata(host_wdata), .host_busy(host_busy),
        .host_done(host_done), .host_rdata(host_rdata), .port_cs_n(port_cs_n),
        .port_wr_n(port_wr_n), .port_rd_n(port_rd_n), .port_addr(port_addr),
        .port_data(port_data), .slv_ready(slv_ready), .slv_irq_id(slv_irq_id)
    );

    // Slave model: separate write and read buffers
    logic [7:0] wbuf [4];
    logic [7:0] rbuf [4];
    initial for (int i = 0; i < 4; i++) wbuf[i] = 8'h00;
    assign port_data = (!port_cs_n && !port_rd_n) ? rbuf[port_addr] : 8'hzz;
    always @(posedge port_wr_n) if (!port_cs_n) wbuf[port_addr] <= port_data;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Port-side monitor: strobe order, width, gaps, control rules
    int strobe_log_addr [$];
    int strobe_log_wid  [$];
    int gap_bad = 0, rule_bad = 0, low_run = 0, strobe_cnt = 0;
    bit cs_seen_high = 1'b1;
    always @(negedge clk) if (rst_n) begin
        if (port_cs_n) cs_seen_high = 1'b1;
        if ((!port_wr_n || !port_rd_n) && port_cs_n) rule_bad++;
        if (!port_wr_n && !port_rd_n) rule_bad++;
        if (!port_wr_n || !port_rd_n) begin
            if (low_run == 0) begin
                if (!cs_seen_high) gap_bad++;
                cs_seen_high = 1'b0;
                strobe_log_addr.push_back(int'(port_addr));
                strobe_cnt++;
            end
            low_run++;
        end else if (low_run != 0) begin
            strobe_log_wid.push_back(low_run);
            low_run = 0;
        end
    end

    // Scoreboard
    logic [31:0] exp_q [$];
    string       tag_q [$];
    always @(negedge clk) if (rst_n && host_done && dut_expect_result) begin
        if (exp_q.size() == 0) check(1'b0, "scoreboard-empty", host_rdata, 32'h0);
        else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(host_rdata === e, t, host_rdata, e);
        end
    end
    bit dut_expect_result = 1'b0;

    int last_lat;
    task automatic host_op(input bit sel, input bit we, input logic [31:0] wd,
                           input bit has_exp, input logic [31:0] exp, input string tag);
        int lat = 0;
        bit busy_ok = 1'b1;
        @(negedge clk);
        if (has_exp) begin exp_q.push_back(exp); tag_q.push_back(tag); end
        dut_expect_result = has_exp;
        host_sel = sel; host_we = we; host_wdata = wd; host_req = 1'b1;
        forever begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            host_req = 1'b0;
            if (!host_busy) busy_ok = 1'b0;
            if (host_done || lat > 500) break;
        end
        last_lat = lat;
        check(busy_ok, "R6 busy held", 32'(busy_ok), 32'h1);
        @(negedge clk);
        dut_expect_result = 1'b0;
    endtask

    task automatic check_write_cycles(input string tag);
        check(strobe_log_addr.size() == 4, {tag, " R1 four byte cycles"},
              strobe_log_addr.size(), 4);
        for (int i = 0; i < strobe_log_addr.size() && i < 4; i++)
            check(strobe_log_addr[i] == i, {tag, " R3 address order"}, strobe_log_addr[i], i);
        for (int i = 0; i < strobe_log_wid.size(); i++)
            check(strobe_log_wid[i] == STRB, {tag, " R5 strobe width"}, strobe_log_wid[i], STRB);
        strobe_log_addr.delete();
        strobe_log_wid.delete();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] w;
        rbuf[0] = 8'h11; rbuf[1] = 8'h22; rbuf[2] = 8'h33; rbuf[3] = 8'h44;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        check(port_cs_n && port_wr_n && port_rd_n, "R10 controls high",
              {29'b0, port_cs_n, port_wr_n, port_rd_n}, 32'h7);
        check(!host_busy && !host_done, "R10 busy/done low", {30'b0, host_busy, host_done}, 0);
        check(host_rdata == 0, "R10 rdata zero", host_rdata, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 write, little-endian placement
        host_op(1'b0, 1'b1, 32'hA1B2C3D4, 1'b0, 0, "");
        check(last_lat == DATA_LAT, "R6 write latency", last_lat, DATA_LAT);
        w = {wbuf[3], wbuf[2], wbuf[1], wbuf[0]};
        check(w == 32'hA1B2C3D4, "R1 write bytes", w, 32'hA1B2C3D4);
        check_write_cycles("wr1");

        host_op(1'b0, 1'b1, 32'h00FF7E01, 1'b0, 0, "");
        w = {wbuf[3], wbuf[2], wbuf[1], wbuf[0]};
        check(w == 32'h00FF7E01, "R1 write bytes 2", w, 32'h00FF7E01);
        check_write_cycles("wr2");

        // R2 read packing
        host_op(1'b0, 1'b0, 32'h0, 1'b1, 32'h44332211, "R2 read pack");
        check(last_lat == DATA_LAT, "R6 read latency", last_lat, DATA_LAT);
        check_write_cycles("rd1");
        rbuf[0] = 8'hF0; rbuf[1] = 8'h0F; rbuf[2] = 8'hAA; rbuf[3] = 8'h55;
        host_op(1'b0, 1'b0, 32'h0, 1'b1, 32'h55AA0FF0, "R2 read pack 2");
        check_write_cycles("rd2");

        // R7 status layout
        slv_ready = 1'b1; slv_irq_id = 3'd5;
        repeat (3) @(negedge clk);
        host_op(1'b1, 1'b0, 32'h0, 1'b1, 32'h0000000B, "R7 status rdy=1 id=5");
        check(last_lat == 1, "R7 status latency", last_lat, 1);
        slv_ready = 1'b0; slv_irq_id = 3'd6;
        repeat (3) @(negedge clk);
        host_op(1'b1, 1'b0, 32'h0, 1'b1, 32'h0000000C, "R7 status rdy=0 id=6");

        // R8 status write ignored
        strobe_cnt = 0;
        w = {wbuf[3], wbuf[2], wbuf[1], wbuf[0]};
        host_op(1'b1, 1'b1, 32'hFFFFFFFF, 1'b0, 0, "");
        check(last_lat == 1, "R8 status write latency", last_lat, 1);
        check(strobe_cnt == 0, "R8 no port cycle", strobe_cnt, 0);
        check(host_rdata == 32'h0000000C, "R8 rdata unchanged", host_rdata, 32'hC);
        check({wbuf[3], wbuf[2], wbuf[1], wbuf[0]} == w, "R8 buffer unchanged",
              {wbuf[3], wbuf[2], wbuf[1], wbuf[0]}, w);
        host_op(1'b1, 1'b0, 32'h0, 1'b1, 32'h0000000C, "R8 status after write");

        // R9 synchronizer delay: change half a clock before request
        @(negedge clk);
        exp_q.push_back(32'h0000000C); tag_q.push_back("R9 old value on immediate read");
        dut_expect_result = 1'b1;
        slv_ready = 1'b1; slv_irq_id = 3'd3;
        host_sel = 1'b1; host_we = 1'b0; host_req = 1'b1;
        @(negedge clk);
        host_req = 1'b0;
        @(negedge clk);
        dut_expect_result = 1'b0;
        host_op(1'b1, 1'b0, 32'h0, 1'b1, 32'h00000007, "R9 new value after two edges");

        // R4 / R5 port rules over the whole run
        check(rule_bad == 0, "R4 strobe/cs rules", rule_bad, 0);
        check(gap_bad == 0, "R5 cs high between bytes", gap_bad, 0);
        check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule